// File: doc/BRIEF.md
# Speed-Selectable RGB Colour Sequencer

This block walks a 3-bit colour control word through all eight on/off combinations of a red, green and blue LED. The word is a binary count that goes up by one per step and wraps from 7 back to 0. A 2-bit speed input chooses how often the count steps: not at all, every tenth of a second, every fifth of a second, or once a second. All three rates come from one shared clock divider that is retargeted while the block runs.

A single counter divides the system clock. The speed input picks which terminal value the counter compares against. When the counter reaches that value, it produces a one-cycle enable that advances the colour, and then it starts again from zero. If the speed input changes, the counter goes back to zero, so the new rate always begins with a full period. While the sequence is paused, the counter stays at zero. The three divisors are parameters. Their defaults give 10 Hz, 5 Hz and 1 Hz from a 50 MHz clock, and a testbench can set them to a few cycles each.

Top module: `rgb_cycle_seq`

## Requirements
- R1: While `rst_n` is low, `rgb` is 000. This takes effect at once, without waiting for a clock edge, and the divider count is cleared.
- R2: Each step raises `rgb` by exactly one, modulo eight: 000, 001, 010, 011, 100, 101, 110, 111, and then back to 000.
- R3: While `speed_sel` is 00, `rgb` keeps its value and the divider count stays at zero.
- R4: While `speed_sel` stays at 01, steps are FAST_DIV clock cycles apart. The default is 5,000,000, which is 10 Hz at 50 MHz.
- R5: While `speed_sel` stays at 10, steps are MID_DIV clock cycles apart. The default is 10,000,000, which is 5 Hz.
- R6: While `speed_sel` stays at 11, steps are SLOW_DIV clock cycles apart. The default is 50,000,000, which is 1 Hz.
- R7: A clock edge that samples a `speed_sel` value different from the one sampled at the edge before makes no step, even if the count is at its terminal value, and it restarts the count from zero. The first step at the new rate comes exactly the new divisor's number of edges later.
- R8: Every divisor must be at least 2. With that in place, `rgb` never changes on two clock edges in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst_n | input | 1 | Asynchronous reset, active low |
| speed_sel | input | 2 | 00 pause, 01 fast, 10 medium, 11 slow |
| rgb | output | 3 | Colour control word as a binary count |

## Verification
Two events can fall on the same clock edge: the divider reaching its terminal count, and a change of the speed select. The bench watches its own model's count. On the exact cycle before the model expects a step, it switches `speed_sel`. The change must win: `rgb` must hold on that edge, and the next step must come one full new period later. The bench repeats this for each pair of running rates, and it also applies random select changes. Step intervals are measured at the ports, both against a cycle-by-cycle model and against the divisor of the speed in effect.

// File: rtl/rgb_cycle_pkg.sv
`timescale 1ns/1ps
package rgb_cycle_pkg;

    typedef enum logic [1:0] {
        SPD_HOLD = 2'b00,
        SPD_FAST = 2'b01,
        SPD_MID  = 2'b10,
        SPD_SLOW = 2'b11
    } speed_e;

    typedef logic [2:0] colour_t;

    typedef struct packed {
        logic run;
        logic restart;
    } div_ctl_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic colour_t next_colour(input colour_t c);
        return c + colour_t'(1);
    endfunction

endpackage

// File: rtl/rgb_speed_decode.sv
`timescale 1ns/1ps
module rgb_speed_decode
    import rgb_cycle_pkg::*;
#(
    parameter int unsigned FAST_DIV = 5_000_000,
    parameter int unsigned MID_DIV  = 10_000_000,
    parameter int unsigned SLOW_DIV = 50_000_000,
    parameter int unsigned CNT_W    = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  speed_e           sel,
    output div_ctl_t         ctl,
    output logic [CNT_W-1:0] term
);

    localparam logic [CNT_W-1:0] TERM_FAST = CNT_W'(FAST_DIV - 1);
    localparam logic [CNT_W-1:0] TERM_MID  = CNT_W'(MID_DIV - 1);
    localparam logic [CNT_W-1:0] TERM_SLOW = CNT_W'(SLOW_DIV - 1);

    speed_e sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= SPD_HOLD;
        end else begin
            sel_q <= sel;
        end
    end

    always_comb begin
        ctl.run     = (sel != SPD_HOLD);
        ctl.restart = (sel != sel_q);
        unique case (sel)
            SPD_FAST: term = TERM_FAST;
            SPD_MID:  term = TERM_MID;
            SPD_SLOW: term = TERM_SLOW;
            default:  term = '0;
        endcase
    end

endmodule

// File: rtl/rgb_tick_divider.sv
`timescale 1ns/1ps
module rgb_tick_divider
    import rgb_cycle_pkg::*;
#(
    parameter int unsigned CNT_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  div_ctl_t         ctl,
    input  logic [CNT_W-1:0] term,
    output logic             tick
);

    logic [CNT_W-1:0] cnt;
    logic             at_term;

    assign at_term = (cnt == term);
    assign tick    = ctl.run && !ctl.restart && at_term;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!ctl.run || ctl.restart || at_term) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/rgb_colour_stepper.sv
`timescale 1ns/1ps
module rgb_colour_stepper
    import rgb_cycle_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    output colour_t colour
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            colour <= '0;
        end else if (tick) begin
            colour <= next_colour(colour);
        end
    end

endmodule

// File: rtl/rgb_cycle_seq.sv
`timescale 1ns/1ps
module rgb_cycle_seq
    import rgb_cycle_pkg::*;
#(
    parameter int unsigned FAST_DIV = 5_000_000,
    parameter int unsigned MID_DIV  = 10_000_000,
    parameter int unsigned SLOW_DIV = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] speed_sel,
    output logic [2:0] rgb
);

    localparam int unsigned MAX_DIV = max3(FAST_DIV, MID_DIV, SLOW_DIV);
    localparam int unsigned CNT_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

    div_ctl_t         ctl;
    logic [CNT_W-1:0] term;
    logic             tick;
    colour_t          colour;

    rgb_speed_decode #(
        .FAST_DIV(FAST_DIV),
        .MID_DIV (MID_DIV),
        .SLOW_DIV(SLOW_DIV),
        .CNT_W   (CNT_W)
    ) u_decode (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (speed_e'(speed_sel)),
        .ctl  (ctl),
        .term (term)
    );

    rgb_tick_divider #(
        .CNT_W(CNT_W)
    ) u_divider (
        .clk  (clk),
        .rst_n(rst_n),
        .ctl  (ctl),
        .term (term),
        .tick (tick)
    );

    rgb_colour_stepper u_stepper (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .colour(colour)
    );

    assign rgb = colour;

endmodule

// File: rtl/rgb_cycle_chk.sv
`timescale 1ns/1ps
module rgb_cycle_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] speed_sel,
    input logic [2:0] rgb
);

    // R1: output cleared while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (rgb == 3'd0)
                else $error("rgb not cleared during reset");
        end
    end

    assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rgb != $past(rgb)) |-> (rgb == 3'($past(rgb) + 3'd1)));

    assert_pause_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_sel == 2'b00) |=> $stable(rgb));

    assert_change_no_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_sel != $past(speed_sel)) |=> $stable(rgb));

    assert_no_back_to_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rgb != $past(rgb)) |=> $stable(rgb));

endmodule

bind rgb_cycle_seq rgb_cycle_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .speed_sel(speed_sel),
    .rgb      (rgb)
);

// File: tb/tb_rgb_cycle_seq.sv
`timescale 1ns/1ps
module tb_rgb_cycle_seq;

    localparam int D_FAST = 4;
    localparam int D_MID  = 7;
    localparam int D_SLOW = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] speed_sel = 2'b00;
    logic [2:0] rgb;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    bit started = 0;

    // reference model state
    int m_rgb = 0, m_cnt = 0, m_prev = 0, m_sel = 0;
    int cyc = 0, chg_cyc = 0, last_step = -1, wraps = 0;
    int prev_out = 0;

    always #2 clk = ~clk;

    rgb_cycle_seq #(
        .FAST_DIV(D_FAST),
        .MID_DIV (D_MID),
        .SLOW_DIV(D_SLOW)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .speed_sel(speed_sel),
        .rgb      (rgb)
    );

    function automatic int div_of(input int s);
        case (s)
            1: return D_FAST;
            2: return D_MID;
            3: return D_SLOW;
            default: return 0;
        endcase
    endfunction

    function automatic string rate_tag(input int s);
        case (s)
            1: return "R4";
            2: return "R5";
            3: return "R6";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on every clock edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_rgb = 0; m_cnt = 0; m_prev = 0; m_sel = 0;
            cyc = 0; chg_cyc = 0; last_step = -1;
        end else begin
            bit adv;
            adv = 0;
            cyc++;
            m_sel = int'(speed_sel);
            if (m_sel != m_prev) begin
                chg_cyc = cyc;
                m_cnt = 0;
            end else if (m_sel == 0) begin
                m_cnt = 0;
            end else if (m_cnt == div_of(m_sel) - 1) begin
                m_cnt = 0;
                adv = 1;
            end else begin
                m_cnt++;
            end
            if (adv) m_rgb = (m_rgb + 1) % 8;
            m_prev = m_sel;
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_out = 0;
        end else if (started && !done) begin
            check((m_sel == 0) ? "R3" : "R2", int'(rgb), m_rgb);
            if (int'(rgb) != prev_out) begin
                if (last_step > chg_cyc)
                    check(rate_tag(m_sel), cyc - last_step, div_of(m_sel));
                else
                    check("R7", cyc - chg_cyc, div_of(m_sel));
                check("R8", (cyc - last_step > 1) ? 1 : 0, 1);
                if (rgb == 3'd0) wraps++;
                last_step = cyc;
            end
            prev_out = int'(rgb);
        end
    end

    task automatic run(input logic [1:0] s, input int n);
        @(negedge clk); #1;
        speed_sel = s;
        repeat (n) @(negedge clk);
    endtask

    task automatic collide(input logic [1:0] a, input logic [1:0] b);
        logic [2:0] held;
        @(negedge clk); #1;
        speed_sel = a;
        forever begin
            @(negedge clk); #1;
            if (m_prev == int'(a) && m_cnt == div_of(int'(a)) - 1) break;
        end
        held = rgb;
        speed_sel = b;
        @(negedge clk);
        check("R7", int'(rgb), int'(held));
        repeat (div_of(int'(b)) + 3) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        logic [2:0] frozen;
        repeat (3) @(negedge clk);
        check("R1", int'(rgb), 0);
        #1 rst_n = 1'b1;
        started = 1;

        run(2'b01, 45);
        run(2'b10, 60);
        run(2'b11, 80);
        frozen = rgb;
        run(2'b00, 30);
        check("R3", int'(rgb), int'(frozen));
        run(2'b01, 9);

        // asynchronous reset in mid-run
        @(negedge clk); #1;
        rst_n = 1'b0;
        #0.5;
        check("R1", int'(rgb), 0);
        @(negedge clk); #1;
        rst_n = 1'b1;
        run(2'b01, 20);

        repeat (3) begin
            collide(2'b01, 2'b10);
            collide(2'b10, 2'b11);
            collide(2'b11, 2'b01);
        end

        repeat (40) run(2'($urandom_range(0, 3)), int'($urandom_range(1, 15)));
        run(2'b01, 40);

        check("R2", (wraps > 0) ? 1 : 0, 1);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog: actual cycles %0d expected completion earlier", cyc);
            summary();
            $finish;
        end
    end

endmodule